// File: doc/BRIEF.md
# Clock Holdover Entry/Exit Controller

This block is the decision logic of a two-stage clock-cleaning PLL. It watches the first loop's lock indication, a loss-of-signal flag for the active reference and a flag raised when the tuning voltage hits its rail. Each of the three can be enabled as a holdover trigger on its own. A qualifying trigger produces a single-cycle clock-switch pulse that carries the selected switch style, hitless or hard, and puts the controller into holdover when holdover is allowed.

Holdover ends only after the first loop has delivered a programmed number of valid phase-detector cycles in a row. A valid cycle is a phase-detector enable while lock is high and loss-of-signal is low. The threshold is a 14-bit value. A separate path reports whether one manually chosen input must be forced as the only selectable reference.

The configuration pins are sampled into a register on every clock. A synchronous active-low reset loads that register with the default configuration, so the defaults are in force on the first cycle after reset is released.

Top module: `hov_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the outputs read holdover 0, switch pulse 0, switch style 1 (hitless) and force-valid 0. The configuration in force is then: override 0, all three trigger enables 0, hitless 1, holdover enable 1, exit threshold 2.
- R2: With the lock trigger enabled, a 1-to-0 transition of lock-detect raises the switch pulse at the next clock edge, and the block enters holdover at that same edge when holdover is enabled. A lock-detect that simply stays low raises nothing further.
- R3: With the loss-of-signal trigger enabled, a 0-to-1 change of loss-of-signal raises one switch pulse. With that enable clear, loss-of-signal raises no pulse and no holdover.
- R4: With the tuning-rail trigger enabled, a 0-to-1 change of the rail flag raises one switch pulse. With that enable clear, the rail flag is ignored.
- R5: While the registered holdover enable is 0, the block is out of holdover at the next edge, whatever the triggers do. Triggers still raise the switch pulse.
- R6: On every switch pulse, the switch-style output equals the registered hitless bit (1 = hitless, 0 = hard). It holds that value until the next pulse.
- R7: In holdover, each valid phase-detector cycle (enable high, lock high, loss-of-signal low) is compared against the threshold. When the count of earlier valid cycles is at or above the threshold, holdover drops at the next edge. Otherwise the count increments. A threshold of 0 therefore exits on the first valid cycle, and threshold N exits on valid cycle N+1.
- R8: In holdover, any cycle with lock low or loss-of-signal high clears the exit count. A new trigger also clears the count and keeps the block in holdover.
- R9: Simultaneous trigger sources produce a single one-cycle pulse. A level source held high produces no further pulses until it drops and rises again.
- R10: When the registered override bit is 1 and the registered input selection code is 0, 1 or 2, force-valid is 1 and the forced-input output equals that code. For any other code, or with override 0, force-valid is 0.
- R11: Every configuration pin takes effect one clock after it is driven, because all of them pass through the reset-loaded configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_lock_i | input | 1 | First-loop digital lock-detect |
| ref_los_i | input | 1 | Loss-of-signal for the active reference |
| vtune_rail_i | input | 1 | Tuning voltage has reached its rail |
| pdf_en_i | input | 1 | One-cycle enable per first-loop phase-detector cycle |
| cfg_override_i | input | 1 | Force the manually selected input |
| cfg_lock_trig_en_i | input | 1 | Lock-loss trigger enable |
| cfg_los_trig_en_i | input | 1 | Loss-of-signal trigger enable |
| cfg_vtune_trig_en_i | input | 1 | Tuning-rail trigger enable |
| cfg_hitless_i | input | 1 | 1 hitless switching, 0 hard switching |
| cfg_hold_en_i | input | 1 | Holdover allowed |
| cfg_exit_cnt_i | input | 14 | Valid cycles before holdover exit |
| sel_mode_i | input | 2 | Input selection code; 0..2 are manual inputs |
| holdover_o | output | 1 | Holdover active |
| switch_evt_o | output | 1 | One-cycle clock-switch event |
| switch_hitless_o | output | 1 | Switch style of the latest event |
| force_sel_valid_o | output | 1 | One manual input is forced |
| force_sel_o | output | 2 | Index of the forced input |

## Verification
The bench builds the block with its default parameters: a 14-bit exit count, a 2-bit selection code and three manual inputs. At the 14-bit width, thresholds of 0, 1, 2 and the top value 16383 all fit within the run. The top value is driven once with a valid cycle on every clock, so the full-width compare is exercised. With the 2-bit code, every selection value can be visited, including the one non-manual code that must not force an input.

// File: rtl/hov_pkg.sv
// Package: shared types and reset constants for the holdover controller.
// Assumes: all users import it; the flag struct excludes widths that are
// parameters of the top module.
package hov_pkg;

    // Single-bit configuration controls, grouped for one register.
    typedef struct packed {
        logic ovr;
        logic lock_en;
        logic los_en;
        logic vt_en;
        logic hitless;
        logic hold_en;
    } hov_flags_t;

    // Reset image of the flag register.
    localparam hov_flags_t HOV_FLAGS_RST = '{
        ovr:     1'b0,
        lock_en: 1'b0,
        los_en:  1'b0,
        vt_en:   1'b0,
        hitless: 1'b1,
        hold_en: 1'b1
    };

    // Controller state.
    typedef enum logic {
        HOV_TRACK = 1'b0,
        HOV_HOLD  = 1'b1
    } hov_state_t;

endpackage

// File: rtl/hov_cfg_reg.sv
// Module: configuration register with reset defaults, plus the decode of the
// forced-input indication.
// Assumes: synchronous active-low reset; NUM_MANUAL < 2**SEL_W.
module hov_cfg_reg
    import hov_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int EXIT_RST   = 2,
    parameter int SEL_W      = 2,
    parameter int NUM_MANUAL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hov_flags_t       flags_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic [SEL_W-1:0] sel_i,
    output hov_flags_t       flags_q,
    output logic [CNT_W-1:0] thr_q,
    output logic             force_valid_o,
    output logic [SEL_W-1:0] force_sel_o
);
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(EXIT_RST);
    localparam logic [SEL_W-1:0] SEL_RST = {SEL_W{1'b1}};
    localparam logic [SEL_W-1:0] SEL_LIM = SEL_W'(NUM_MANUAL);

    logic [SEL_W-1:0] sel_q;

    // Capture configuration each cycle; reset loads the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= HOV_FLAGS_RST;
            thr_q   <= THR_RST;
            sel_q   <= SEL_RST;
        end else begin
            flags_q <= flags_i;
            thr_q   <= thr_i;
            sel_q   <= sel_i;
        end
    end

    // Forced selection applies only to manual input codes.
    always_comb begin
        force_valid_o = flags_q.ovr && (sel_q < SEL_LIM);
        force_sel_o   = force_valid_o ? sel_q : '0;
    end

endmodule

// File: rtl/hov_trig_detect.sv
// Module: turns the lock, loss-of-signal and tuning-rail flags into a single
// combinational trigger. Lock contributes on its falling edge; level sources
// contribute on the rise of their combined, enabled level.
// Assumes: inputs are already synchronous to clk.
module hov_trig_detect
    import hov_pkg::*;
#(
    parameter int NUM_LVL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic               lock_en_i,
    input  logic [NUM_LVL-1:0] lvl_i,
    input  logic [NUM_LVL-1:0] lvl_en_i,
    output logic               trig_o
);
    logic               lock_q;
    logic               lvl_any_q;
    logic [NUM_LVL-1:0] lvl_gated;
    logic               lvl_any;
    logic               lock_fall;

    // Gate each level source by its own enable.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign lvl_gated[g] = lvl_i[g] & lvl_en_i[g];
    end

    // History registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= 1'b0;
            lvl_any_q <= 1'b0;
        end else begin
            lock_q    <= lock_i;
            lvl_any_q <= lvl_any;
        end
    end

    // Merge all sources into one trigger.
    always_comb begin
        lvl_any   = |lvl_gated;
        lock_fall = lock_en_i & lock_q & ~lock_i;
        trig_o    = lock_fall | (lvl_any & ~lvl_any_q);
    end

endmodule

// File: rtl/hov_exit_cnt.sv
// Module: counts valid phase-detector cycles toward the exit threshold.
// Assumes: clr_i has priority over counting; hit_o is combinational.
module hov_exit_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;

    // Threshold reached on a valid cycle.
    assign hit_o = valid_i && (cnt_q >= thr_i);

    // Count valid cycles; clear on request or on reaching the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || hit_o) begin
            cnt_q <= '0;
        end else if (valid_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hov_ctrl.sv
// Module: top of the holdover controller. Registers the configuration,
// detects triggers, runs the track/hold state machine and the exit counter.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module hov_ctrl
    import hov_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int EXIT_RST   = 2,
    parameter int SEL_W      = 2,
    parameter int NUM_MANUAL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pll_lock_i,
    input  logic             ref_los_i,
    input  logic             vtune_rail_i,
    input  logic             pdf_en_i,
    input  logic             cfg_override_i,
    input  logic             cfg_lock_trig_en_i,
    input  logic             cfg_los_trig_en_i,
    input  logic             cfg_vtune_trig_en_i,
    input  logic             cfg_hitless_i,
    input  logic             cfg_hold_en_i,
    input  logic [CNT_W-1:0] cfg_exit_cnt_i,
    input  logic [SEL_W-1:0] sel_mode_i,
    output logic             holdover_o,
    output logic             switch_evt_o,
    output logic             switch_hitless_o,
    output logic             force_sel_valid_o,
    output logic [SEL_W-1:0] force_sel_o
);
    localparam int NUM_LVL = 2;

    hov_flags_t       flags_in;
    hov_flags_t       flags_q;
    logic [CNT_W-1:0] thr_q;
    logic             trig;
    logic             valid;
    logic             cnt_clr;
    logic             cnt_hit;
    hov_state_t       state_q;
    hov_state_t       state_d;

    // Pack the configuration pins.
    always_comb begin
        flags_in.ovr     = cfg_override_i;
        flags_in.lock_en = cfg_lock_trig_en_i;
        flags_in.los_en  = cfg_los_trig_en_i;
        flags_in.vt_en   = cfg_vtune_trig_en_i;
        flags_in.hitless = cfg_hitless_i;
        flags_in.hold_en = cfg_hold_en_i;
    end

    hov_cfg_reg #(
        .CNT_W      (CNT_W),
        .EXIT_RST   (EXIT_RST),
        .SEL_W      (SEL_W),
        .NUM_MANUAL (NUM_MANUAL)
    ) cfg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .flags_i       (flags_in),
        .thr_i         (cfg_exit_cnt_i),
        .sel_i         (sel_mode_i),
        .flags_q       (flags_q),
        .thr_q         (thr_q),
        .force_valid_o (force_sel_valid_o),
        .force_sel_o   (force_sel_o)
    );

    hov_trig_detect #(
        .NUM_LVL (NUM_LVL)
    ) trig_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (pll_lock_i),
        .lock_en_i (flags_q.lock_en),
        .lvl_i     ({vtune_rail_i, ref_los_i}),
        .lvl_en_i  ({flags_q.vt_en, flags_q.los_en}),
        .trig_o    (trig)
    );

    // Qualify phase-detector cycles and decide when the count restarts.
    always_comb begin
        valid   = pdf_en_i & pll_lock_i & ~ref_los_i;
        cnt_clr = trig | (state_q != HOV_HOLD) | ~pll_lock_i | ref_los_i
                  | ~flags_q.hold_en;
    end

    hov_exit_cnt #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .valid_i (valid),
        .thr_i   (thr_q),
        .hit_o   (cnt_hit)
    );

    // Next state: disable wins, then triggers, then exit on threshold.
    always_comb begin
        state_d = state_q;
        if (!flags_q.hold_en) begin
            state_d = HOV_TRACK;
        end else if (trig) begin
            state_d = HOV_HOLD;
        end else if (state_q == HOV_HOLD && cnt_hit) begin
            state_d = HOV_TRACK;
        end
    end

    // State, event pulse and switch-style registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= HOV_TRACK;
            switch_evt_o     <= 1'b0;
            switch_hitless_o <= HOV_FLAGS_RST.hitless;
        end else begin
            state_q      <= state_d;
            switch_evt_o <= trig;
            if (trig) begin
                switch_hitless_o <= flags_q.hitless;
            end
        end
    end

    assign holdover_o = (state_q == HOV_HOLD);

endmodule

// File: rtl/hov_ctrl_chk.sv
// Module: assertion checker for hov_ctrl, attached by bind below.
// Assumes: observes ports plus the registered configuration bits.
module hov_ctrl_chk #(
    parameter int SEL_W      = 2,
    parameter int NUM_MANUAL = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_i,
    input logic             los_i,
    input logic             pdf_en_i,
    input logic             hold_en_q,
    input logic             hitless_q,
    input logic             holdover_o,
    input logic             switch_evt_o,
    input logic             switch_hitless_o,
    input logic             force_valid_o,
    input logic [SEL_W-1:0] force_sel_o
);
    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (!holdover_o && !switch_evt_o && switch_hitless_o && !force_valid_o));

    // R2
    hold_entry_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holdover_o) |-> switch_evt_o);

    // R5
    disabled_leaves_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_en_q |=> !holdover_o);

    // R6
    event_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_evt_o |-> (switch_hitless_o == $past(hitless_q)));

    // R7
    exit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holdover_o) |-> ($past(!hold_en_q) || $past(lock_i && !los_i && pdf_en_i)));

    // R10
    forced_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_valid_o |-> (force_sel_o < SEL_W'(NUM_MANUAL)));

endmodule

bind hov_ctrl hov_ctrl_chk #(
    .SEL_W      (SEL_W),
    .NUM_MANUAL (NUM_MANUAL)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .lock_i           (pll_lock_i),
    .los_i            (ref_los_i),
    .pdf_en_i         (pdf_en_i),
    .hold_en_q        (flags_q.hold_en),
    .hitless_q        (flags_q.hitless),
    .holdover_o       (holdover_o),
    .switch_evt_o     (switch_evt_o),
    .switch_hitless_o (switch_hitless_o),
    .force_valid_o    (force_sel_valid_o),
    .force_sel_o      (force_sel_o)
);

// File: tb/hov_ctrl_tb_top.sv
// Bench: drives the controller and compares every output against a
// behavioural model on every clock.
module hov_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock = 1'b1, los = 1'b0, vt = 1'b0, pdf = 1'b0;
    logic        c_ovr = 1'b1, c_lock_en = 1'b1, c_los_en = 1'b0, c_vt_en = 1'b0;
    logic        c_hit = 1'b0, c_hen = 1'b0;
    logic [13:0] c_thr = 14'd9;
    logic [1:0]  c_sel = 2'd0;
    logic        d_hold, d_evt, d_hsty, d_fv;
    logic [1:0]  d_fsel;

    int    n_cmp = 0, n_bad = 0;
    string req = "R1";
    bit    done = 1'b0;

    // model state
    int m_ovr, m_len, m_losen, m_vten, m_hit, m_hen, m_thr, m_sel;
    int m_lockp, m_lvlp, m_hold, m_cnt, m_evt, m_sty;

    always #10 clk = ~clk;

    hov_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .pll_lock_i (lock), .ref_los_i (los), .vtune_rail_i (vt), .pdf_en_i (pdf),
        .cfg_override_i (c_ovr), .cfg_lock_trig_en_i (c_lock_en),
        .cfg_los_trig_en_i (c_los_en), .cfg_vtune_trig_en_i (c_vt_en),
        .cfg_hitless_i (c_hit), .cfg_hold_en_i (c_hen),
        .cfg_exit_cnt_i (c_thr), .sel_mode_i (c_sel),
        .holdover_o (d_hold), .switch_evt_o (d_evt), .switch_hitless_o (d_hsty),
        .force_sel_valid_o (d_fv), .force_sel_o (d_fsel)
    );

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ovr = 0; m_len = 0; m_losen = 0; m_vten = 0; m_hit = 1; m_hen = 1;
            m_thr = 2; m_sel = 3; m_lockp = 0; m_lvlp = 0; m_hold = 0; m_cnt = 0;
            m_evt = 0; m_sty = 1;
        end else begin
            int fall, lvl, trig, vld;
            fall = (m_lockp == 1 && lock == 1'b0 && m_len == 1) ? 1 : 0;
            lvl  = ((los && m_losen == 1) || (vt && m_vten == 1)) ? 1 : 0;
            trig = (fall == 1 || (lvl == 1 && m_lvlp == 0)) ? 1 : 0;
            vld  = (pdf && lock && !los) ? 1 : 0;
            if (m_hen == 0) begin
                m_hold = 0; m_cnt = 0;
            end else if (trig == 1) begin
                m_hold = 1; m_cnt = 0;
            end else if (m_hold == 1) begin
                if (!lock || los) m_cnt = 0;
                else if (vld == 1) begin
                    if (m_cnt >= m_thr) begin m_hold = 0; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end else m_cnt = 0;
            m_evt = trig;
            if (trig == 1) m_sty = m_hit;
            m_lockp = lock; m_lvlp = lvl;
            m_ovr = c_ovr; m_len = c_lock_en; m_losen = c_los_en; m_vten = c_vt_en;
            m_hit = c_hit; m_hen = c_hen; m_thr = c_thr; m_sel = c_sel;
        end
    end

    task automatic cmp1(string nm, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Compare all outputs at the falling edge, then let the driver change inputs.
    always @(negedge clk) begin
        if (!done) begin
            int fv;
            fv = (m_ovr == 1 && m_sel < 3) ? 1 : 0;
            cmp1("holdover_o", d_hold, m_hold);
            cmp1("switch_evt_o", d_evt, m_evt);
            cmp1("switch_hitless_o", d_hsty, m_sty);
            cmp1("force_sel_valid_o", d_fv, fv);
            cmp1("force_sel_o", d_fsel, fv == 1 ? m_sel : 0);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic run_valid(int n);
        for (int i = 0; i < n; i++) begin pdf = 1'b1; step(1); end
        pdf = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        // R1: reset with non-default pins, defaults must show on release
        step(4);
        rst_n = 1'b1;
        step(1);
        c_ovr = 0; c_lock_en = 0; c_hit = 1; c_hen = 1; c_thr = 14'd2; c_sel = 2'd3;
        step(3);
        // R11 / R2: lock trigger enabled, one falling edge, then held low
        req = "R11"; c_lock_en = 1; step(1);
        req = "R2";  lock = 0; step(1); step(5);
        lock = 1; step(1);
        req = "R7"; run_valid(4); step(2);
        // R2: lock low without enable gives nothing
        req = "R2"; c_lock_en = 0; step(1); lock = 0; step(3); lock = 1; step(2);
        // R3: loss-of-signal ignored, then enabled and held
        req = "R3"; los = 1; step(3); los = 0; step(1);
        c_los_en = 1; step(1); los = 1; step(4); los = 0; step(1);
        // R8: count restarts on lock drop and loss reassertion
        req = "R8"; c_thr = 14'd3; step(1);
        run_valid(2); lock = 0; pdf = 1; step(1); lock = 1; pdf = 0; run_valid(3);
        los = 1; step(2); los = 0; run_valid(5); step(2);
        // R4 and R6: tuning rail with hard switching
        req = "R4"; c_vt_en = 0; vt = 1; step(2); vt = 0; step(1);
        req = "R6"; c_vt_en = 1; c_hit = 0; step(1); vt = 1; step(3); vt = 0; run_valid(6);
        c_hit = 1; step(1); lock = 0; c_lock_en = 1; step(2); lock = 1; run_valid(5);
        // R9: three sources on the same cycle
        req = "R9"; step(1); lock = 0; los = 1; vt = 1; step(1); step(3);
        lock = 1; los = 0; vt = 0; run_valid(6);
        // R8: new trigger while holding restarts the count
        req = "R8"; los = 1; step(1); los = 0; run_valid(2); vt = 1; step(1); vt = 0; run_valid(6);
        // R5: disabled holdover, then disable while holding
        req = "R5"; c_hen = 0; step(1); los = 1; step(2); los = 0; step(2);
        c_hen = 1; step(1); los = 1; step(1); los = 0; step(2); c_hen = 0; step(3); c_hen = 1; step(1);
        // R7: thresholds 0, 1 and the top value
        req = "R7"; c_thr = 14'd0; step(1); los = 1; step(1); los = 0; step(2); run_valid(2);
        c_thr = 14'd1; step(1); los = 1; step(1); los = 0; run_valid(3);
        c_thr = 14'h3FFF; step(1); los = 1; step(1); los = 0; run_valid(16386); step(2);
        // R10: override across all selection codes
        req = "R10";
        for (int s = 0; s < 4; s++) begin c_sel = 2'(s); c_ovr = 1; step(2); c_ovr = 0; step(1); end
        // R9: pseudo-random mixed stimulus
        req = "R9"; lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lock = (lf[3:0] != 4'd0); los = (lf[7:4] == 4'd5); vt = (lf[11:8] == 4'd9);
            pdf = lf[12]; c_hen = (lf[15:13] != 3'd0); c_hit = lf[14];
            c_lock_en = lf[1]; c_los_en = lf[2]; c_vt_en = lf[5];
            c_thr = {11'd0, lf[10:8]}; c_sel = lf[7:6]; c_ovr = lf[9];
            step(1);
        end
        step(2);
        finish_run();
    end

endmodule